// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

A single-channel timer peripheral on a plain synchronous register bus. Software writes a byte address, a write strobe and 32 bits of data; read data is a combinational function of the address. The channel holds a 32-bit down-counter. It decrements on prescaled ticks, which come from one of four tick-enable inputs divided by a power of two. When the count runs out, the channel either reloads an interval value and keeps going, or stops at zero. Either way a pending flag is raised, and that flag drives a level interrupt when it is enabled.

The channel's run control is a two-state machine. State IDLE holds the count. State COUNT decrements it. The transitions are named as follows. START goes IDLE to COUNT, on a control write with the run bit set. HALT goes COUNT to IDLE, on a control write with the run bit clear. EXPIRE_RELOAD stays in COUNT, on a prescaled tick at count 1 or 0 in auto-reload mode. EXPIRE_STOP goes COUNT to IDLE, on such a tick in single-shot mode. DECREMENT stays in COUNT, on a prescaled tick at a count above 1. A write to the current-value register overrides the count in either state.

Top module: `ivt_top`

## Requirements
- R1: After reset every register reads 0, the timer is stopped and `irq` is low.
- R2: Register map, at byte addresses 0x00, 0x04, 0x10, 0x14 and 0x18:
  - 0x00 is the interrupt enable. Only bit 0 is stored.
  - 0x04 is the status register. Bit 0 is the pending flag.
  - 0x10 is the control word. Bit 0 is run, bit 1 is auto-reload, bits [3:2] are the source code and bits [6:4] are the prescale code.
  - 0x14 is the interval.
  - 0x18 is the current count.
  - Unstored bits and any other address read 0. The run bit reads back the machine state, where 1 means COUNT.
- R3: With prescale code n (0 to 7), the count decrements once for every 2^n selected source ticks while in COUNT. The prescaler restarts from zero whenever the channel is in IDLE.
- R4: Source code k selects `src_tick[k]`, and code 1 is the main oscillator tick. Ticks on the inputs that are not selected have no effect on the count.
- R5: In auto-reload mode, a prescaled tick while the count is 1 or 0 loads the interval and sets the pending flag, and the channel stays in COUNT. The period is therefore interval × 2^n selected ticks.
- R6: In single-shot mode, such a tick sets the pending flag, leaves the count at 0 and returns the channel to IDLE, so the run bit reads 0.
- R7: A control write with bit 0 clear stops the channel, and the count is held while in IDLE. A prescaled tick that falls in a cycle with a control write is discarded.
- R8: A write to 0x18 replaces the count in either state. A prescaled tick in that same cycle is discarded.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the flag stays set.
- R10: `irq` is high exactly when status bit 0 and enable bit 0 are both 1.
- R11: With source 1 ticking every cycle, prescale code 4 and interval 1500, expiries are 24000 cycles apart. This is one per millisecond for a 24 MHz source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Tick enables of the four clock sources |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- each expiry raises the pending flag and, when enabled, the interrupt;
- a reload brings in the interval, and a single-shot expiry leaves IDLE at count zero;
- a non-final prescaled tick lowers the count by exactly one;
- a count write lands on the next cycle;
- the count and the prescaler stay frozen in IDLE.

The bench scenarios are needed for the things no single-cycle property covers:
- the division ratio over whole periods, including the 24000-cycle millisecond case;
- the isolation of the unselected sources;
- set-wins-over-clear on the status flag;
- the register readback map.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int ADDR_W   = 8;
    localparam int CODE_W   = 3;
    localparam int SRC_W    = 2;

    localparam logic [ADDR_W-1:0] A_IRQ_EN = 8'h00;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h10;
    localparam logic [ADDR_W-1:0] A_IVAL   = 8'h14;
    localparam logic [ADDR_W-1:0] A_CUR    = 8'h18;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] presc;
        logic [SRC_W-1:0]  src;
        logic              auto_rl;
    } ctrl_cfg_t;

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale
    import ivt_pkg::*;
#(
    parameter int NSRC = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [CODE_W-1:0] code,
    input  logic              running,
    output logic              ptick
);
    localparam int DIV_W = (1 << CODE_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;
    logic             sel_tick;

    assign sel_tick = src_tick[src_sel];
    assign limit    = (DIV_W'(1) << code) - DIV_W'(1);
    assign ptick    = running && sel_tick && (div_cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!running) begin
            div_cnt <= '0;
        end else if (sel_tick) begin
            if (div_cnt >= limit) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             run_wbit,
    input  logic             cur_wr,
    input  logic [CNT_W-1:0] cur_wdata,
    input  logic             ptick,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] interval,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: START / HALT / EXPIRE_RELOAD / EXPIRE_STOP / DECREMENT
    always_comb begin
        state_d = state_q;
        count_d = count;
        expire  = 1'b0;
        if (cur_wr) begin
            count_d = cur_wdata;
        end else if (ctrl_wr) begin
            state_d = run_wbit ? ST_COUNT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COUNT: begin
                    if (ptick) begin
                        if (count <= CNT_W'(1)) begin
                            expire = 1'b1;
                            if (auto_rl) begin
                                count_d = interval;
                            end else begin
                                count_d = '0;
                                state_d = ST_IDLE;
                            end
                        end else begin
                            count_d = count - CNT_W'(1);
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_d;
        end
    end

    assign running = (state_q == ST_COUNT);

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic [DATA_W-1:0] count,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctrl_wr,
    output logic              cur_wr,
    output ctrl_cfg_t         cfg,
    output logic [DATA_W-1:0] interval,
    output logic              st0,
    output logic              ie0,
    output logic              irq
);
    localparam int CFG_W = $bits(ctrl_cfg_t);

    logic ie_wr, st_wr, ival_wr;

    assign ie_wr   = bus_we && (bus_addr == A_IRQ_EN);
    assign st_wr   = bus_we && (bus_addr == A_STATUS);
    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign ival_wr = bus_we && (bus_addr == A_IVAL);
    assign cur_wr  = bus_we && (bus_addr == A_CUR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie0      <= 1'b0;
            st0      <= 1'b0;
            cfg      <= '0;
            interval <= '0;
        end else begin
            if (ie_wr) begin
                ie0 <= bus_wdata[0];
            end
            st0 <= (st0 && !(st_wr && bus_wdata[0])) || expire;
            if (ctrl_wr) begin
                cfg <= bus_wdata[CFG_W:1];
            end
            if (ival_wr) begin
                interval <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IRQ_EN: bus_rdata[0] = ie0;
            A_STATUS: bus_rdata[0] = st0;
            A_CTRL:   bus_rdata[CFG_W:0] = {cfg, running};
            A_IVAL:   bus_rdata = interval;
            A_CUR:    bus_rdata = count;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = st0 && ie0;

endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              ctrl_wr, cur_wr, running, expire, ptick, st0, ie0;
    ctrl_cfg_t         cfg;
    logic [DATA_W-1:0] interval, count;

    ivt_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .running(running), .count(count),
        .expire(expire), .bus_rdata(bus_rdata), .ctrl_wr(ctrl_wr),
        .cur_wr(cur_wr), .cfg(cfg), .interval(interval), .st0(st0),
        .ie0(ie0), .irq(irq)
    );

    ivt_prescale #(.NSRC(NSRC)) presc_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(cfg.src),
        .code(cfg.presc), .running(running), .ptick(ptick)
    );

    ivt_counter #(.CNT_W(DATA_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .run_wbit(bus_wdata[0]),
        .cur_wr(cur_wr), .cur_wdata(bus_wdata), .ptick(ptick),
        .auto_rl(cfg.auto_rl), .interval(interval), .running(running),
        .count(count), .expire(expire)
    );

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              st0,
    input logic              ie0,
    input logic              expire,
    input logic              running,
    input logic              auto_rl,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] interval,
    input logic              ptick,
    input logic              cur_wr,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] wdata
);
    p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st0);

    p_expire_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ie0 |=> irq || !ie0);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && auto_rl |=> running && count == $past(interval));

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !auto_rl |=> !running && count == '0);

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running && ptick && !cur_wr && !ctrl_wr && count > DATA_W'(1)
        |=> count == $past(count) - DATA_W'(1));

    p_idle_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !ptick);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !cur_wr |=> $stable(count));

    p_cur_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> count == $past(wdata));

endmodule

bind ivt_top ivt_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .st0(st0), .ie0(ie0),
    .expire(expire), .running(running), .auto_rl(cfg.auto_rl),
    .count(count), .interval(interval), .ptick(ptick), .cur_wr(cur_wr),
    .ctrl_wr(ctrl_wr), .wdata(bus_wdata)
);

// File: tb/ivt_top_tb_top.sv
`timescale 1ns/1ps
module ivt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = 4'h0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    tick_mode = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    ivt_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [31:0] m_cnt = 0, m_ival = 0;
    bit        m_run = 0, m_auto = 0, m_ie = 0, m_st = 0;
    int        m_src = 0, m_presc = 0, m_pcnt = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_ival = 0; m_run = 0; m_auto = 0; m_ie = 0;
            m_st = 0; m_src = 0; m_presc = 0; m_pcnt = 0;
        end else begin
            bit sel, ptk, exp_now, cw, uw;
            int np, lim;
            sel = src_tick[m_src];
            lim = (1 << m_presc) - 1;
            ptk = m_run && sel && (m_pcnt >= lim);
            if (!m_run) np = 0;
            else if (sel) np = ptk ? 0 : m_pcnt + 1;
            else np = m_pcnt;
            cw = bus_we && bus_addr == 8'h10;
            uw = bus_we && bus_addr == 8'h18;
            exp_now = 0;
            if (uw) m_cnt = bus_wdata;
            else if (cw) m_run = bus_wdata[0];
            else if (m_run && ptk) begin
                if (m_cnt <= 1) begin
                    exp_now = 1;
                    if (m_auto) m_cnt = m_ival;
                    else begin m_cnt = 0; m_run = 0; end
                end else m_cnt = m_cnt - 1;
            end
            if (bus_we && bus_addr == 8'h00) m_ie = bus_wdata[0];
            m_st = (m_st && !(bus_we && bus_addr == 8'h04 && bus_wdata[0])) || exp_now;
            if (cw) begin
                m_auto  = bus_wdata[1];
                m_src   = int'(bus_wdata[3:2]);
                m_presc = int'(bus_wdata[6:4]);
            end
            if (bus_we && bus_addr == 8'h14) m_ival = bus_wdata;
            m_pcnt = np;
        end
    end

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h00: return {31'b0, m_ie};
            8'h04: return {31'b0, m_st};
            8'h10: return {25'b0, 3'(m_presc), 2'(m_src), m_auto, m_run};
            8'h14: return m_ival;
            8'h18: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [31:0] er;
            er = model_read(bus_addr);
            check(bus_rdata == er, cur_req, "rdata vs model", bus_rdata, er);
            check(irq == (m_st && m_ie), "R10", "irq vs model", irq, m_st && m_ie);
        end
    end

    // source tick stimulus
    bit [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: src_tick = 4'hF;
            1: src_tick = lfsr[3:0];
            default: src_tick = 4'b1101;
        endcase
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit [7:0] a, output bit [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_irq(output int t);
        int k = 0;
        t = -1;
        while (k < 30000) begin
            @(negedge clk);
            if (irq) begin t = cyc; break; end
            k++;
        end
    endtask

    task automatic measure(input int expect_p, input string req);
        int t1, t2;
        wr(8'h04, 1);
        wait_irq(t1);
        wr(8'h04, 1);
        wait_irq(t2);
        check(t1 >= 0 && t2 >= 0 && (t2 - t1) == expect_p, req,
              "expiry period", t2 - t1, expect_p);
    endtask

    // watchdog
    initial begin
        #(5ns * 190000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] v, v2;
        // R1 reset
        idle(3);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        foreach (dut_i.bus_rdata[i]) ; // no-op
        begin
            bit [7:0] addrs [6] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h08};
            foreach (addrs[i]) begin
                rd(addrs[i], v);
                check(v == 0, "R1", "register after reset", v, 0);
            end
        end
        check(irq == 0, "R1", "irq after reset", irq, 0);

        // R2 register map
        cur_req = "R2";
        wr(8'h14, 32'h1234_5678);
        rd(8'h14, v); check(v == 32'h1234_5678, "R2", "interval readback", v, 32'h1234_5678);
        wr(8'h10, 32'hFFFF_FF7E);
        rd(8'h10, v); check(v == 32'h7E, "R2", "control readback", v, 32'h7E);
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h00, v); check(v == 0, "R2", "enable bit0 only", v, 0);
        rd(8'h0C, v); check(v == 0, "R2", "unmapped read", v, 0);
        wr(8'h18, 32'hCAFE_0001);
        rd(8'h18, v); check(v == 32'hCAFE_0001, "R2", "current readback", v, 32'hCAFE_0001);

        // R3 prescaler: interval 4, code 3 -> 32 cycles
        cur_req = "R3";
        tick_mode = 0;
        wr(8'h00, 1);
        wr(8'h14, 4);
        wr(8'h18, 4);
        wr(8'h10, 32'h37);            // presc 3, src 1, auto, run
        measure(32, "R3");
        wr(8'h10, 32'h77);            // presc 7 -> 512
        measure(512, "R3");

        // R4 source select
        cur_req = "R4";
        tick_mode = 2;                // src_tick[1] held low
        wr(8'h18, 100);
        wr(8'h10, 32'h07);            // presc 0, src 1, auto, run
        rd(8'h18, v); idle(20); rd(8'h18, v2);
        check(v == v2 && v == 100, "R4", "count with unselected ticks", v2, 100);
        tick_mode = 1;
        wr(8'h10, 32'h1B);            // presc 1, src 2, auto, run
        idle(60);
        rd(8'h18, v);
        check(v < 100, "R4", "count moves on source 2", v, 99);

        // R5 auto-reload period
        cur_req = "R5";
        tick_mode = 0;
        wr(8'h14, 5);
        wr(8'h10, 32'h07);
        measure(5, "R5");
        rd(8'h10, v); check(v[0] == 1, "R5", "still running after reload", v[0], 1);

        // R6 single-shot
        cur_req = "R6";
        wr(8'h10, 32'h00);
        wr(8'h04, 1);
        wr(8'h18, 3);
        wr(8'h10, 32'h15);            // presc 1, src 1, single, run
        idle(20);
        rd(8'h10, v);  check(v[0] == 0, "R6", "run bit after single shot", v[0], 0);
        rd(8'h18, v);  check(v == 0, "R6", "count after single shot", v, 0);
        rd(8'h04, v);  check(v == 1, "R6", "status after single shot", v, 1);

        // R7 halt
        cur_req = "R7";
        wr(8'h18, 1000);
        wr(8'h10, 32'h07);
        idle(10);
        wr(8'h10, 32'h06);
        rd(8'h18, v); idle(15); rd(8'h18, v2);
        check(v == v2 && v < 1000, "R7", "count held after halt", v2, v);

        // R8 overwrite while running
        cur_req = "R8";
        wr(8'h14, 200);
        wr(8'h10, 32'h07);
        idle(5);
        wr(8'h18, 32'h50);
        rd(8'h18, v);
        check(v <= 32'h50 && v >= 32'h4E, "R8", "count after overwrite", v, 32'h50);

        // R9 status clear semantics
        cur_req = "R9";
        wr(8'h10, 32'h06);
        wr(8'h04, 0);
        rd(8'h04, v);  check(v == 1, "R9", "write 0 keeps status", v, 1);
        wr(8'h04, 1);
        rd(8'h04, v);  check(v == 0, "R9", "write 1 clears status", v, 0);
        wr(8'h14, 1);
        wr(8'h18, 1);
        wr(8'h10, 32'h07);            // expires every cycle
        idle(3);
        wr(8'h04, 1);
        rd(8'h04, v);  check(v == 1, "R9", "set wins over clear", v, 1);
        wr(8'h10, 32'h06);

        // R10 irq gating
        cur_req = "R10";
        wr(8'h00, 0);
        @(negedge clk); check(irq == 0, "R10", "irq masked", irq, 0);
        wr(8'h00, 1);
        @(negedge clk); check(irq == 1, "R10", "irq enabled", irq, 1);

        // R11 millisecond interval
        cur_req = "R11";
        wr(8'h14, 1500);
        wr(8'h18, 1500);
        wr(8'h10, 32'h47);            // presc 4, src 1, auto, run
        measure(24000, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule